// File: doc/BRIEF.md
# Colour Sensor Acquisition Sequencer

This controller sits on the host side of a colour light sensor and drives it through a byte-wide register-access command port. The bit-level bus work is left to that port. A single start request can do several things in order. It can first pulse the sensor's active-low reset and wait for the sensor to recover. It then loads all per-channel gain settings and triggers either a colour measurement or an offset measurement. After that it polls the sensor's control register until the self-clearing trigger bit has dropped, and finally fetches every channel result.

Colour results are four 10-bit values rebuilt from low/high byte pairs. Offset results are four sign-magnitude bytes, which the block presents as 8-bit two's-complement numbers. When a complete result set is ready, the block marks it with a one-cycle valid strobe. A poll limit stops a sensor that never finishes, and raises a timeout flag. An error reported by the command port stops the sequence at once and raises an error flag. Neither kind of aborted sequence produces a valid strobe.

The state machine has eight named states. IDLE waits for start. RST_LOW holds the sensor reset low. RST_WAIT is the recovery gap. GAIN issues the twelve gain writes. TRIG issues the trigger write. POLL issues control-register reads. FETCH issues the result reads. DONE emits the valid strobe.

The transitions are as follows:
- IDLE goes to RST_LOW on start with the reset option set, and to GAIN on start without it.
- RST_LOW goes to RST_WAIT after the low width.
- RST_WAIT goes to GAIN after the wait.
- GAIN goes to TRIG after its last write.
- TRIG goes to POLL.
- POLL goes to FETCH when a read returns zero. It goes to IDLE when the limit is reached, which sets the timeout flag.
- FETCH goes to DONE after its last read.
- DONE goes to IDLE.
- Any command state goes to IDLE on a port error, which sets the error flag.

Top module: `colour_acq_seq`

## Requirements
- R1: After reset, busy, valid, command request, error and timeout are all low, the sensor reset output is high, and all result outputs are zero.
- R2: When start is taken with `sns_reset_i` high, `sns_rst_n_o` goes low for exactly RST_LOW_CYC cycles. It then stays high for exactly RST_WAIT_CYC cycles before the first command is requested. With `sns_reset_i` low, no reset pulse occurs.
- R3: The first twelve commands are writes. Addresses 0x06..0x09 receive `{4'b0, cap}` for red, green, blue and clear. Addresses 0x0A..0x11 receive the 12-bit integration counts as a low byte followed by `{4'b0, count[11:8]}` in the same channel order. Channel c is `cap_i[4c+3:4c]` and `integ_i[12c+11:12c]`, where c = 0 red, 1 green, 2 blue, 3 clear.
- R4: The trigger is a write to address 0x00 of 0x01 in colour mode (`ofs_mode_i` = 0 at start) or 0x02 in offset mode.
- R5: After the trigger, the block reads address 0x00 repeatedly until a read returns 0x00.
- R6: In colour mode, results are read from 0x40..0x47 in order. Channel c of `colour_o[10c+9:10c]` equals `{hi[1:0], lo}`, where lo is read from 0x40+2c and hi from 0x41+2c.
- R7: In offset mode, results are read from 0x48..0x4B. Channel c of `offset_o[8c+7:8c]` is the two's complement of the sign-magnitude byte, where bit 7 set means negative. A negative zero yields 0.
- R8: If POLL_MAX consecutive polls return nonzero, polling stops, `timeout_o` rises, no valid strobe is issued and no further command follows.
- R9: A command completed with `cmd_err_i` high ends the sequence: `err_o` rises, no valid strobe is issued and no further command follows.
- R10: `res_valid_o` is a one-cycle pulse one cycle after the final result read completes. Start is ignored while busy, and a new start clears both flags.
- R11: Commands are issued one at a time. Request, direction, address and write data stay steady from request until the cycle `cmd_done_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a sequence (taken in IDLE only) |
| ofs_mode_i | input | 1 | 0 colour reading, 1 offset reading |
| sns_reset_i | input | 1 | Pulse the sensor reset before the sequence |
| cap_i | input | 16 | Four 4-bit capacitor counts |
| integ_i | input | 48 | Four 12-bit integration counts |
| cmd_req_o | output | 1 | Command request, held until done |
| cmd_write_o | output | 1 | 1 write, 0 read |
| cmd_addr_o | output | 8 | Sensor register address |
| cmd_wdata_o | output | 8 | Write byte |
| cmd_done_i | input | 1 | Command completed this cycle |
| cmd_err_i | input | 1 | Command failed (valid with done) |
| cmd_rdata_i | input | 8 | Read byte (valid with done) |
| sns_rst_n_o | output | 1 | Active-low sensor reset |
| busy_o | output | 1 | Sequence in progress |
| res_valid_o | output | 1 | Results valid strobe |
| colour_o | output | 40 | Four 10-bit colour results |
| offset_o | output | 32 | Four 8-bit signed offsets |
| timeout_o | output | 1 | Polling limit reached |
| err_o | output | 1 | Command port error seen |

## Verification
The next command request appears on the cycle after `cmd_done_i` is accepted. The valid strobe appears exactly one cycle after the done of the last result read, and the flags rise on that same cycle. The sensor reset low width and the quiet gap are exact cycle counts. The bench's responder model answers each command a fixed two cycles after it sees the request, and it compares every command against a queue of expected commands filled by the driver. The monitors record the cycle of every done and check at falling edges that the strobe lands on the following cycle and that reset widths match the parameters exactly.

// File: rtl/colacq_pkg.sv
package colacq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_RST_LOW, ST_RST_WAIT, ST_GAIN,
        ST_TRIG, ST_POLL, ST_FETCH, ST_DONE
    } acq_state_t;

    localparam int CH_N   = 4;
    localparam int CH_W   = $clog2(CH_N);
    localparam int CAP_W  = 4;
    localparam int INT_W  = 12;
    localparam int BYTE_W = 8;
    localparam int COL_W  = 10;
    localparam int OFS_W  = 8;
    localparam int STEP_W = 4;

    localparam int GAIN_WRITES = CH_N * 3;
    localparam int COL_READS   = CH_N * 2;
    localparam int OFS_READS   = CH_N;

    localparam logic [7:0] ADDR_CTRL = 8'h00;
    localparam logic [7:0] ADDR_CAP  = 8'h06;
    localparam logic [7:0] ADDR_INTG = 8'h0A;
    localparam logic [7:0] ADDR_COL  = 8'h40;
    localparam logic [7:0] ADDR_OFS  = 8'h48;
    localparam logic [7:0] GO_SENSOR = 8'h01;
    localparam logic [7:0] GO_OFFSET = 8'h02;
endpackage

// File: rtl/colacq_cmd_gen.sv
module colacq_cmd_gen
    import colacq_pkg::*;
(
    input  acq_state_t               state_i,
    input  logic [STEP_W-1:0]        step_i,
    input  logic                     ofs_mode_i,
    input  logic [CH_N*CAP_W-1:0]    cap_i,
    input  logic [CH_N*INT_W-1:0]    integ_i,
    output logic                     req_o,
    output logic                     wr_o,
    output logic [BYTE_W-1:0]        addr_o,
    output logic [BYTE_W-1:0]        wdata_o
);
    logic [STEP_W-1:0] k;
    logic [CH_W-1:0]   ch;

    always_comb begin
        req_o   = 1'b0;
        wr_o    = 1'b0;
        addr_o  = '0;
        wdata_o = '0;
        k       = step_i - STEP_W'(CH_N);
        ch      = k[CH_W:1];
        unique case (state_i)
            ST_GAIN: begin
                req_o = 1'b1;
                wr_o  = 1'b1;
                if (step_i < STEP_W'(CH_N)) begin
                    addr_o  = ADDR_CAP + BYTE_W'(step_i);
                    wdata_o = BYTE_W'(cap_i[step_i[CH_W-1:0]*CAP_W +: CAP_W]);
                end else begin
                    addr_o = ADDR_INTG + BYTE_W'(k);
                    if (k[0])
                        wdata_o = BYTE_W'(integ_i[ch*INT_W + BYTE_W +: INT_W-BYTE_W]);
                    else
                        wdata_o = integ_i[ch*INT_W +: BYTE_W];
                end
            end
            ST_TRIG: begin
                req_o   = 1'b1;
                wr_o    = 1'b1;
                addr_o  = ADDR_CTRL;
                wdata_o = ofs_mode_i ? GO_OFFSET : GO_SENSOR;
            end
            ST_POLL: begin
                req_o  = 1'b1;
                addr_o = ADDR_CTRL;
            end
            ST_FETCH: begin
                req_o  = 1'b1;
                addr_o = (ofs_mode_i ? ADDR_OFS : ADDR_COL) + BYTE_W'(step_i);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/colacq_ofs_conv.sv
module colacq_ofs_conv
    import colacq_pkg::*;
(
    input  logic [OFS_W-1:0] raw_i,
    output logic [OFS_W-1:0] val_o
);
    logic             neg;
    logic [OFS_W-2:0] mag;

    always_comb begin
        neg   = raw_i[OFS_W-1];
        mag   = raw_i[OFS_W-2:0];
        val_o = neg ? (~{1'b0, mag} + 1'b1) : {1'b0, mag};
        // R7: a negative input and its result sum to zero
        if (neg) begin
            a_r7_sign_mag: assert (OFS_W'(val_o + {1'b0, mag}) == '0);
        end
    end
endmodule

// File: rtl/colour_acq_seq.sv
module colour_acq_seq
    import colacq_pkg::*;
#(
    parameter int POLL_MAX     = 256,
    parameter int RST_LOW_CYC  = 200,
    parameter int RST_WAIT_CYC = 2000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    ofs_mode_i,
    input  logic                    sns_reset_i,
    input  logic [15:0]             cap_i,
    input  logic [47:0]             integ_i,
    output logic                    cmd_req_o,
    output logic                    cmd_write_o,
    output logic [7:0]              cmd_addr_o,
    output logic [7:0]              cmd_wdata_o,
    input  logic                    cmd_done_i,
    input  logic                    cmd_err_i,
    input  logic [7:0]              cmd_rdata_i,
    output logic                    sns_rst_n_o,
    output logic                    busy_o,
    output logic                    res_valid_o,
    output logic [39:0]             colour_o,
    output logic [31:0]             offset_o,
    output logic                    timeout_o,
    output logic                    err_o
);
    localparam int PW   = $clog2(POLL_MAX + 1);
    localparam int TMAX = (RST_LOW_CYC > RST_WAIT_CYC) ? RST_LOW_CYC : RST_WAIT_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    acq_state_t        st_q, st_d;
    logic [STEP_W-1:0] step_q;
    logic [TW-1:0]     tmr_q;
    logic [PW-1:0]     poll_q;
    logic              mode_q, err_q, tmo_q;
    logic [COL_W-1:0]  col_q     [CH_N];
    logic [OFS_W-1:0]  ofs_raw_q [CH_N];
    logic              acc, last_gain, last_fetch, ctrl_clear, poll_last;

    assign acc        = cmd_req_o && cmd_done_i;
    assign last_gain  = step_q == STEP_W'(GAIN_WRITES - 1);
    assign last_fetch = step_q == (mode_q ? STEP_W'(OFS_READS - 1) : STEP_W'(COL_READS - 1));
    assign ctrl_clear = cmd_rdata_i == 8'h00;
    assign poll_last  = poll_q == PW'(POLL_MAX - 1);

    colacq_cmd_gen u_cmd (
        .state_i    (st_q),
        .step_i     (step_q),
        .ofs_mode_i (mode_q),
        .cap_i      (cap_i),
        .integ_i    (integ_i),
        .req_o      (cmd_req_o),
        .wr_o       (cmd_write_o),
        .addr_o     (cmd_addr_o),
        .wdata_o    (cmd_wdata_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:     if (start_i) st_d = sns_reset_i ? ST_RST_LOW : ST_GAIN;
            ST_RST_LOW:  if (tmr_q == TW'(RST_LOW_CYC - 1)) st_d = ST_RST_WAIT;
            ST_RST_WAIT: if (tmr_q == TW'(RST_WAIT_CYC - 1)) st_d = ST_GAIN;
            ST_GAIN:     if (acc) st_d = cmd_err_i ? ST_IDLE : (last_gain ? ST_TRIG : ST_GAIN);
            ST_TRIG:     if (acc) st_d = cmd_err_i ? ST_IDLE : ST_POLL;
            ST_POLL: if (acc) begin
                if (cmd_err_i)       st_d = ST_IDLE;
                else if (ctrl_clear) st_d = ST_FETCH;
                else if (poll_last)  st_d = ST_IDLE;
            end
            ST_FETCH:    if (acc) st_d = cmd_err_i ? ST_IDLE : (last_fetch ? ST_DONE : ST_FETCH);
            ST_DONE:     st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sns_rst_n_o = st_q != ST_RST_LOW;
        busy_o      = st_q != ST_IDLE;
        res_valid_o = st_q == ST_DONE;
        err_o       = err_q;
        timeout_o   = tmo_q;
    end

    // counters, flags and result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
            tmr_q  <= '0;
            poll_q <= '0;
            mode_q <= 1'b0;
            err_q  <= 1'b0;
            tmo_q  <= 1'b0;
            for (int c = 0; c < CH_N; c++) begin
                col_q[c]     <= '0;
                ofs_raw_q[c] <= '0;
            end
        end else begin
            if (st_d != st_q) begin
                step_q <= '0;
                tmr_q  <= '0;
            end else begin
                if (st_q == ST_RST_LOW || st_q == ST_RST_WAIT) tmr_q <= tmr_q + 1'b1;
                if (acc && st_q != ST_POLL) step_q <= step_q + 1'b1;
            end
            if (st_q != ST_POLL) poll_q <= '0;
            else if (acc)        poll_q <= poll_q + 1'b1;
            if (st_q == ST_IDLE && start_i) begin
                mode_q <= ofs_mode_i;
                err_q  <= 1'b0;
                tmo_q  <= 1'b0;
            end
            if (acc && cmd_err_i) err_q <= 1'b1;
            if (st_q == ST_POLL && acc && !cmd_err_i && !ctrl_clear && poll_last) tmo_q <= 1'b1;
            if (st_q == ST_FETCH && acc && !cmd_err_i) begin
                if (mode_q)
                    ofs_raw_q[step_q[CH_W-1:0]] <= cmd_rdata_i;
                else if (step_q[0])
                    col_q[step_q[CH_W:1]][COL_W-1:BYTE_W] <= cmd_rdata_i[COL_W-BYTE_W-1:0];
                else
                    col_q[step_q[CH_W:1]][BYTE_W-1:0] <= cmd_rdata_i;
            end
        end
    end

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        assign colour_o[c*COL_W +: COL_W] = col_q[c];
        colacq_ofs_conv u_conv (
            .raw_i (ofs_raw_q[c]),
            .val_o (offset_o[c*OFS_W +: OFS_W])
        );
    end

    a_r2_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !sns_rst_n_o |-> !cmd_req_o);
    a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req_o && !cmd_done_i |=> cmd_req_o && $stable(cmd_addr_o)
            && $stable(cmd_wdata_o) && $stable(cmd_write_o));
    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o && !busy_o);
    a_r9_abort_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req_o && cmd_done_i && cmd_err_i |=> !busy_o && err_o);
    a_r8_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> !busy_o && !res_valid_o);
    a_r5_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_POLL |-> poll_q < PW'(POLL_MAX));
endmodule

// File: tb/colour_acq_seq_tb_top.sv
module colour_acq_seq_tb_top;
    localparam int POLL_MAX = 4;
    localparam int RST_LOW  = 5;
    localparam int RST_WAIT = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, ofs_mode_i = 1'b0, sns_reset_i = 1'b0;
    logic [15:0] cap_i = '0;
    logic [47:0] integ_i = '0;
    logic        cmd_req_o, cmd_write_o;
    logic [7:0]  cmd_addr_o, cmd_wdata_o;
    logic        cmd_done_i = 1'b0, cmd_err_i = 1'b0;
    logic [7:0]  cmd_rdata_i = '0;
    logic        sns_rst_n_o, busy_o, res_valid_o, timeout_o, err_o;
    logic [39:0] colour_o;
    logic [31:0] offset_o;

    always #2.5 clk = ~clk;

    colour_acq_seq #(.POLL_MAX(POLL_MAX), .RST_LOW_CYC(RST_LOW), .RST_WAIT_CYC(RST_WAIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ofs_mode_i(ofs_mode_i),
        .sns_reset_i(sns_reset_i), .cap_i(cap_i), .integ_i(integ_i),
        .cmd_req_o(cmd_req_o), .cmd_write_o(cmd_write_o), .cmd_addr_o(cmd_addr_o),
        .cmd_wdata_o(cmd_wdata_o), .cmd_done_i(cmd_done_i), .cmd_err_i(cmd_err_i),
        .cmd_rdata_i(cmd_rdata_i), .sns_rst_n_o(sns_rst_n_o), .busy_o(busy_o),
        .res_valid_o(res_valid_o), .colour_o(colour_o), .offset_o(offset_o),
        .timeout_o(timeout_o), .err_o(err_o)
    );

    int n_chk = 0, n_err = 0;
    int cyc = 0, last_done_cyc = -10;
    int busy_left = 0, poll_nz = 0, err_at = -1, cmd_idx = 0;
    int low_cnt = 0, gap_cnt = 0, push_n = 0, push_lim = 0;
    bit armed = 0;
    logic [7:0]  regs [0:127];
    logic [16:0] exp_cmd_q [$];
    logic [72:0] exp_res_q [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [72:0] act, input logic [72:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [7:0] a, input logic wr);
        if (a == 8'h00) return wr ? "R4" : "R5";
        if (a < 8'h40)  return "R3";
        if (a < 8'h48)  return "R6";
        return "R7";
    endfunction

    // command port responder and command scoreboard
    initial forever begin
        @(negedge clk);
        if (rst_n && cmd_req_o) begin
            logic wr; logic [7:0] a, d; logic [16:0] e;
            wr = cmd_write_o; a = cmd_addr_o; d = cmd_wdata_o;
            if (exp_cmd_q.size() == 0)
                chk(0, "R11", "unexpected command", {wr, a, d}, '0);
            else begin
                e = exp_cmd_q.pop_front();
                chk(e[16] == wr && e[15:8] == a && (!wr || e[7:0] == d),
                    tag_of(e[15:8], e[16]), "command", {wr, a, d}, e);
            end
            repeat (2) @(negedge clk);
            if (wr) begin
                regs[a] = d;
                if (a == 8'h00) busy_left = poll_nz;
                cmd_rdata_i = 8'h00;
            end else if (a == 8'h00) begin
                if (busy_left > 0) begin cmd_rdata_i = regs[0]; busy_left--; end
                else cmd_rdata_i = 8'h00;
            end else cmd_rdata_i = regs[a];
            cmd_err_i  = (cmd_idx == err_at);
            cmd_idx++;
            cmd_done_i = 1'b1;
            last_done_cyc = cyc;
            @(negedge clk);
            cmd_done_i = 1'b0;
            cmd_err_i  = 1'b0;
        end
    end

    // result monitor
    initial forever begin
        @(negedge clk);
        if (rst_n && res_valid_o) begin
            logic [72:0] e;
            chk(cyc == last_done_cyc + 1, "R10", "strobe cycle", 73'(cyc), 73'(last_done_cyc + 1));
            if (exp_res_q.size() == 0)
                chk(0, "R10", "unexpected valid", {1'b0, colour_o, offset_o}, '0);
            else begin
                e = exp_res_q.pop_front();
                if (e[72]) chk(offset_o == e[31:0], "R7", "offsets", 73'(offset_o), 73'(e[31:0]));
                else       chk(colour_o == e[71:32], "R6", "colours", 73'(colour_o), 73'(e[71:32]));
            end
        end
    end

    // sensor reset monitor
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (!sns_rst_n_o) begin low_cnt++; armed = 1; end
            else if (armed) begin
                if (cmd_req_o) begin
                    chk(low_cnt == RST_LOW, "R2", "reset low width", 73'(low_cnt), 73'(RST_LOW));
                    chk(gap_cnt == RST_WAIT, "R2", "post-reset quiet", 73'(gap_cnt), 73'(RST_WAIT));
                    armed = 0;
                end else gap_cnt++;
            end
        end
    end

    task automatic push_cmd(input logic wr, input logic [7:0] a, input logic [7:0] d);
        if (push_n < push_lim) exp_cmd_q.push_back({wr, a, d});
        push_n++;
    endtask

    function automatic logic [7:0] sm2tc(input logic [7:0] r);
        int v;
        v = r[7] ? -int'(r[6:0]) : int'(r[6:0]);
        return 8'(v);
    endfunction

    task automatic run_seq(input bit mode, input bit dorst, input int polls,
                           input int err_index, input bit exp_tmo, input bit poke);
        logic [39:0] ec; logic [31:0] eo; int npoll;
        push_n = 0;
        push_lim = (err_index >= 0) ? err_index + 1 : 1000;
        for (int c = 0; c < 4; c++) push_cmd(1'b1, 8'(8'h06 + c), {4'h0, cap_i[4*c +: 4]});
        for (int c = 0; c < 4; c++) begin
            push_cmd(1'b1, 8'(8'h0A + 2*c), integ_i[12*c +: 8]);
            push_cmd(1'b1, 8'(8'h0B + 2*c), {4'h0, integ_i[12*c+8 +: 4]});
        end
        push_cmd(1'b1, 8'h00, mode ? 8'h02 : 8'h01);
        npoll = exp_tmo ? POLL_MAX : polls + 1;
        for (int i = 0; i < npoll; i++) push_cmd(1'b0, 8'h00, 8'h00);
        if (!exp_tmo) begin
            for (int i = 0; i < (mode ? 4 : 8); i++)
                push_cmd(1'b0, 8'((mode ? 8'h48 : 8'h40) + i), 8'h00);
            if (err_index < 0) begin
                for (int c = 0; c < 4; c++) begin
                    ec[10*c +: 10] = {regs[8'h41 + 2*c][1:0], regs[8'h40 + 2*c]};
                    eo[8*c +: 8]   = sm2tc(regs[8'h48 + c]);
                end
                exp_res_q.push_back({mode, ec, eo});
            end
        end
        poll_nz = polls; err_at = err_index; cmd_idx = 0;
        low_cnt = 0; gap_cnt = 0; armed = 0;
        ofs_mode_i = mode; sns_reset_i = dorst;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(!err_o && !timeout_o, "R10", "flags cleared on start", {err_o, timeout_o}, '0);
        if (poke) begin
            repeat (20) @(negedge clk);
            ofs_mode_i = ~mode; sns_reset_i = 1'b1;
            start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(exp_cmd_q.size() == 0, exp_tmo ? "R8" : (err_index >= 0 ? "R9" : "R5"),
            "missing commands", 73'(exp_cmd_q.size()), '0);
        chk(exp_res_q.size() == 0, "R10", "strobe count", 73'(exp_res_q.size()), '0);
        chk(err_o == (err_index >= 0), "R9", "error flag", 73'(err_o), 73'(err_index >= 0));
        chk(timeout_o == exp_tmo, "R8", "timeout flag", 73'(timeout_o), 73'(exp_tmo));
        chk(low_cnt == (dorst ? RST_LOW : 0), "R2", "reset pulse count", 73'(low_cnt),
            73'(dorst ? RST_LOW : 0));
        exp_cmd_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) regs[i] = 8'h00;
        regs[8'h40] = 8'h34; regs[8'h41] = 8'hFD;
        regs[8'h42] = 8'hFF; regs[8'h43] = 8'h03;
        regs[8'h44] = 8'h00; regs[8'h45] = 8'h02;
        regs[8'h46] = 8'h81; regs[8'h47] = 8'h00;
        regs[8'h48] = 8'h85; regs[8'h49] = 8'h05;
        regs[8'h4A] = 8'h80; regs[8'h4B] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !res_valid_o && !cmd_req_o && sns_rst_n_o && !err_o && !timeout_o,
            "R1", "idle outputs", {busy_o, res_valid_o, cmd_req_o, sns_rst_n_o, err_o, timeout_o},
            73'b000100);
        chk(colour_o == '0 && offset_o == '0, "R1", "results zero", {colour_o, offset_o}, '0);

        cap_i = {4'h9, 4'h0, 4'hF, 4'h3};
        integ_i = {12'h8A5, 12'h000, 12'hFFF, 12'h123};
        run_seq(1'b0, 1'b1, 2, -1, 1'b0, 1'b0);   // R2 R3 R4 R5 R6
        run_seq(1'b1, 1'b0, 0, -1, 1'b0, 1'b0);   // R7 incl. negative zero
        cap_i = {4'h1, 4'h2, 4'h4, 4'h8};
        integ_i = {12'h00F, 12'hF00, 12'h5A5, 12'hA5A};
        regs[8'h40] = 8'h00; regs[8'h41] = 8'h01; regs[8'h47] = 8'hFE;
        run_seq(1'b0, 1'b0, 1, -1, 1'b0, 1'b1);   // R10 start ignored while busy
        run_seq(1'b0, 1'b0, 100, -1, 1'b1, 1'b0); // R8 timeout
        run_seq(1'b1, 1'b0, 2, 5, 1'b0, 1'b0);    // R9 error during gain writes
        run_seq(1'b0, 1'b1, 2, 14, 1'b0, 1'b0);   // R9 error during polling
        run_seq(1'b1, 1'b0, 3, -1, 1'b0, 1'b0);   // R10 flags clear, R7 again

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule